// File: doc/BRIEF.md
# One-Bit Branch and Jump Predictor

This block keeps a small direct-mapped table of recent control-flow outcomes for a pipelined processor. Every cycle the first fetch stage presents the address it is about to fetch, and the block answers at once with a predicted-taken flag and the address to fetch next. For a conditional branch an entry remembers whether its last execution was taken and where it went. For an unconditional jump it remembers the last target, and the jump is always predicted taken once it has been seen.

When the decode stage resolves a branch or jump, it presents the instruction's address, whether it is a jump, its target, the address of the instruction that actually followed it, and the prediction that was used for it. The block rewrites the matching entry. One cycle later it raises a one-cycle mispredict pulse if the prediction was wrong, so the pipeline can flush the younger instructions. Entries carry no tag, so two addresses that share index bits overwrite each other. A mode input turns prediction off, and then every lookup answers not-taken.

Top module: `branch_guess_table`

## Requirements
- R1: After reset every entry is invalid. Every lookup then gives `lk_taken`=0 and `lk_target`=`lk_pc`+4, and `mispredict` is 0.
- R2: The entry is selected by address bits [9:4] only, and no tag is kept. An update of any address overwrites the entry shared by every address with equal bits [9:4]. Lookups of those addresses return the last write, whatever their other bits are.
- R3: A branch update (`upd_is_jump`=0) resolves as taken when `upd_next_pc` equals `upd_target`, and as not taken otherwise. It stores that outcome and `upd_target`. A later enabled lookup of the entry gives `lk_taken`=1 with `lk_target`=stored target if the branch was taken. If it was not taken, the lookup gives `lk_taken`=0 with `lk_target`=`lk_pc`+4.
- R4: A jump update (`upd_is_jump`=1) is always resolved taken and stores `upd_target`. A later enabled lookup of the entry gives `lk_taken`=1 and `lk_target`=that target.
- R5: While `pred_en`=0, every lookup gives `lk_taken`=0 and `lk_target`=`lk_pc`+4. Updates still write the table, and their effect appears once `pred_en` returns to 1.
- R6: `mispredict` is 1 for exactly the cycle after an update whose resolved direction differs from `upd_pred_taken`. In every other cycle it is 0 unless R7 applies.
- R7: `mispredict` is also 1 in the cycle after an update that was predicted taken, resolved taken, and had `upd_pred_target` different from `upd_target`.
- R8: When a lookup and an update select the same entry in one cycle, the lookup returns the entry's old contents. The new contents are seen from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_en | input | 1 | 1 = use the table, 0 = always predict not taken |
| lk_pc | input | 32 | Address being fetched |
| lk_taken | output | 1 | Predicted taken |
| lk_target | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | A branch or jump is resolved this cycle |
| upd_pc | input | 32 | Address of the resolved instruction |
| upd_is_jump | input | 1 | 1 = unconditional jump, 0 = conditional branch |
| upd_target | input | 32 | Target address of the resolved instruction |
| upd_next_pc | input | 32 | Address of the instruction that really followed it |
| upd_pred_taken | input | 1 | Direction that was predicted for it |
| upd_pred_target | input | 32 | Target that was predicted for it |
| mispredict | output | 1 | One-cycle flush request, the cycle after a wrong update |

## Verification
The lookup answer depends only on the present fetch address, the mode input and the table contents. It is due in the same cycle as the address, so the bench drives inputs just after a falling edge and samples a moment later, before the rising edge writes anything. An update changes the table at the next rising edge, so its effect is first expected at the following step's sample. That ordering also covers the same-entry read-write case. The mispredict flag is registered. The expected value worked out for each update is held back one step and compared at the sample after the edge that captures it.

// File: rtl/branch_guess_table.sv
module branch_guess_table #(
  parameter int AW         = 32,
  parameter int ENTRIES    = 64,
  parameter int IDX_LO     = 4,
  parameter int INSN_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pred_en,
  input  logic [AW-1:0] lk_pc,
  output logic          lk_taken,
  output logic [AW-1:0] lk_target,
  input  logic          upd_valid,
  input  logic [AW-1:0] upd_pc,
  input  logic          upd_is_jump,
  input  logic [AW-1:0] upd_target,
  input  logic [AW-1:0] upd_next_pc,
  input  logic          upd_pred_taken,
  input  logic [AW-1:0] upd_pred_target,
  output logic          mispredict
);
  localparam int IW = $clog2(ENTRIES);

  logic [ENTRIES-1:0] ent_vld;
  logic [ENTRIES-1:0] ent_tkn;
  logic [AW-1:0]      ent_tgt [ENTRIES];

  logic [IW-1:0] rd_idx, wr_idx;
  logic          hit, res_taken, wrong_dir, wrong_tgt;

  assign rd_idx = lk_pc[IDX_LO +: IW];
  assign wr_idx = upd_pc[IDX_LO +: IW];

  assign hit       = pred_en & ent_vld[rd_idx] & ent_tkn[rd_idx];
  assign lk_taken  = hit;
  assign lk_target = hit ? ent_tgt[rd_idx] : lk_pc + AW'(INSN_BYTES);

  assign res_taken = upd_is_jump | (upd_next_pc == upd_target);
  assign wrong_dir = res_taken != upd_pred_taken;
  assign wrong_tgt = res_taken & upd_pred_taken & (upd_pred_target != upd_target);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_vld    <= '0;
      ent_tkn    <= '0;
      mispredict <= 1'b0;
    end else begin
      mispredict <= upd_valid & (wrong_dir | wrong_tgt);
      if (upd_valid) begin
        ent_vld[wr_idx] <= 1'b1;
        ent_tkn[wr_idx] <= res_taken;
      end
    end
  end

  always_ff @(posedge clk)
    if (upd_valid) ent_tgt[wr_idx] <= upd_target;

endmodule

// File: rtl/branch_guess_table_chk.sv
module branch_guess_table_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pred_en,
  input logic [AW-1:0] lk_pc,
  input logic          lk_taken,
  input logic [AW-1:0] lk_target,
  input logic          upd_valid,
  input logic [AW-1:0] upd_pc,
  input logic          upd_is_jump,
  input logic [AW-1:0] upd_target,
  input logic [AW-1:0] upd_next_pc,
  input logic          upd_pred_taken,
  input logic [AW-1:0] upd_pred_target,
  input logic          mispredict
);
  // R6, R7: a flush request only follows an update
  assert_flush_after_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |-> $past(upd_valid));

  // R5: disabled mode never predicts taken
  assert_off_not_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_en |-> !lk_taken);

  // R6: taken branch that was predicted not taken
  assert_missed_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_is_jump && upd_next_pc == upd_target && !upd_pred_taken) |=> mispredict);

  // R4, R7: jump predicted taken with the right target is not flushed
  assert_jump_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_is_jump && upd_pred_taken && upd_pred_target == upd_target) |=> !mispredict);

  // R7: wrong target on a correctly predicted taken jump
  assert_bad_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_is_jump && upd_pred_taken && upd_pred_target != upd_target) |=> mispredict);

  // R1: nothing flushed right after reset
  assert_quiet_reset_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> !mispredict);
endmodule

bind branch_guess_table branch_guess_table_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .pred_en(pred_en), .lk_pc(lk_pc),
  .lk_taken(lk_taken), .lk_target(lk_target), .upd_valid(upd_valid),
  .upd_pc(upd_pc), .upd_is_jump(upd_is_jump), .upd_target(upd_target),
  .upd_next_pc(upd_next_pc), .upd_pred_taken(upd_pred_taken),
  .upd_pred_target(upd_pred_target), .mispredict(mispredict)
);

// File: tb/branch_guess_table_tb_top.sv
module branch_guess_table_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pred_en = 1'b1;
  logic [31:0] lk_pc = '0;
  logic        lk_taken;
  logic [31:0] lk_target;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_is_jump = 1'b0;
  logic [31:0] upd_target = '0;
  logic [31:0] upd_next_pc = '0;
  logic        upd_pred_taken = 1'b0;
  logic [31:0] upd_pred_target = '0;
  logic        mispredict;

  always #10 clk = ~clk;

  branch_guess_table dut_i (
    .clk(clk), .rst_n(rst_n), .pred_en(pred_en), .lk_pc(lk_pc),
    .lk_taken(lk_taken), .lk_target(lk_target), .upd_valid(upd_valid),
    .upd_pc(upd_pc), .upd_is_jump(upd_is_jump), .upd_target(upd_target),
    .upd_next_pc(upd_next_pc), .upd_pred_taken(upd_pred_taken),
    .upd_pred_target(upd_pred_target), .mispredict(mispredict)
  );

  int   n_chk = 0, n_bad = 0;
  bit   done = 0;
  bit   m_vld [int];
  bit   m_tkn [int];
  int unsigned m_tgt [int];
  bit   exp_mp = 0;
  string mp_tag = "R6";

  function automatic int idx_of(logic [31:0] a);
    return int'(a[9:4]);
  endfunction

  function automatic bit mdl_taken(bit en, logic [31:0] a);
    int i = idx_of(a);
    return en && m_vld.exists(i) && m_vld[i] && m_tkn[i];
  endfunction

  function automatic logic [31:0] mdl_target(bit en, logic [31:0] a);
    return mdl_taken(en, a) ? m_tgt[idx_of(a)] : a + 32'd4;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit en, logic [31:0] lpc, bit uv,
                      logic [31:0] upc, bit uj, logic [31:0] utg,
                      logic [31:0] unx, bit upt, logic [31:0] uptg);
    bit rt;
    @(negedge clk);
    pred_en = en; lk_pc = lpc; upd_valid = uv; upd_pc = upc; upd_is_jump = uj;
    upd_target = utg; upd_next_pc = unx; upd_pred_taken = upt; upd_pred_target = uptg;
    #1;
    check(tag, "lk_taken", {31'd0, lk_taken}, {31'd0, mdl_taken(en, lpc)});
    check(tag, "lk_target", lk_target, mdl_target(en, lpc));
    check(mp_tag, "mispredict", {31'd0, mispredict}, {31'd0, exp_mp});
    exp_mp = 0;
    mp_tag = "R6";
    if (uv) begin
      rt = uj || (unx == utg);
      if (rt != upt) exp_mp = 1;
      else if (rt && upt && uptg != utg) begin exp_mp = 1; mp_tag = "R7"; end
      m_vld[idx_of(upc)] = 1;
      m_tkn[idx_of(upc)] = rt;
      m_tgt[idx_of(upc)] = utg;
    end
  endtask

  task automatic look(string tag, bit en, logic [31:0] a);
    step(tag, en, a, 0, '0, 0, '0, '0, 0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: empty table after reset
    for (int k = 0; k < 8; k++) look("R1", 1, 32'h0020_0000 + 32'(k * 144));
    // R3: taken branch, then lookup
    step("R3", 1, 32'h100, 1, 32'h0020_0040, 0, 32'h0020_0100, 32'h0020_0100, 0, '0);
    look("R3", 1, 32'h0020_0040);
    // R3: not-taken branch overwrites
    step("R3", 1, 32'h104, 1, 32'h0020_0040, 0, 32'h0020_0100, 32'h0020_0044, 1, 32'h0020_0100);
    look("R3", 1, 32'h0020_0040);
    // R4: jump learned, then correct prediction, then wrong target (R7)
    step("R4", 1, 32'h0, 1, 32'h0020_0080, 1, 32'h0030_0000, 32'h0030_0000, 0, '0);
    look("R4", 1, 32'h0020_0080);
    step("R4", 1, 32'h0020_0080, 1, 32'h0020_0080, 1, 32'h0030_0000, 32'h0030_0000, 1, 32'h0030_0000);
    step("R7", 1, 32'h0020_0080, 1, 32'h0020_0080, 1, 32'h0030_0040, 32'h0030_0040, 1, 32'h0030_0000);
    look("R7", 1, 32'h0020_0080);
    // R2: alias at +1024 and low bits ignored
    step("R2", 1, 32'h0, 1, 32'h0020_0480, 0, 32'h0040_0000, 32'h0040_0000, 0, '0);
    look("R2", 1, 32'h0020_0080);
    look("R2", 1, 32'h0020_008C);
    look("R2", 1, 32'h0020_0090);
    // R5: disabled mode, table still trained
    step("R5", 0, 32'h0020_0080, 1, 32'h0020_00C0, 1, 32'h0050_0000, 32'h0050_0000, 0, '0);
    look("R5", 0, 32'h0020_00C0);
    look("R5", 1, 32'h0020_00C0);
    // R8: same-entry read and write in one cycle
    step("R8", 1, 32'h0020_00C0, 1, 32'h0020_00C4, 0, 32'h0060_0000, 32'h0020_00C8, 1, 32'h0050_0000);
    look("R8", 1, 32'h0020_00C0);
    // R6: mixed traffic
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] lp, up, tg, nx;
      bit uj, en, upt;
      en = ($urandom % 8) != 0;
      lp = 32'h0020_0000 + (($urandom % 512) << 2);
      up = 32'h0020_0000 + (($urandom % 512) << 2);
      tg = 32'h0020_0000 + (($urandom % 512) << 2);
      uj = ($urandom % 4) == 0;
      nx = ($urandom % 2) ? tg : up + 32'd4;
      upt = ($urandom % 3) == 0 ? ($urandom % 2) == 1 : mdl_taken(1, up);
      step("R6", en, lp, ($urandom % 3) != 0, up, uj, tg, nx, upt,
           ($urandom % 4) == 0 ? tg ^ 32'h10 : mdl_target(1, up));
    end
    look("R6", 1, 32'h0020_0000);
    look("R6", 1, 32'h0020_0004);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule